// File: doc/BRIEF.md
# Address Line Aliasing Tester

This block is a hardware sequencer that looks for broken or shorted memory address lines. It works by checking whether a test word and a partner word share the same storage. The two words differ in exactly one address bit. After a start pulse it captures a region, given as a base byte address and a size in bytes. It then drives a single-port, word-wide memory through every one-bit flip of the test address that can be tested.

For each partner that lies inside the region, the block does three things. It reads the partner. It writes the complement of that value into the test word. It then reads the partner a second time. If that second read returns the complemented value, the two addresses alias, and the block records the test address, the partner address and the flip mask.

The check runs in two passes. The first pass places the test word at the region base, so a single 1 walks through zeros. The second pass places it at the last word of the region, so a single 0 walks through ones. The run ends at the first aliasing pair found, or after both passes. A one-cycle `done` pulse then marks the end, and `fault` gives the verdict.

States:
- `ST_IDLE`: waits for `start`.
- `ST_PICK`: forms the partner and tests whether it is in range. In range goes to `ST_RD_A`. Out of range goes to `ST_STEP`.
- `ST_RD_A`: first partner read, then `ST_WR_T`.
- `ST_WR_T`: writes the complement into the test word, then `ST_RD_B`.
- `ST_RD_B`: second partner read, then `ST_CMP`.
- `ST_CMP`: a match goes to `ST_DONE`. A mismatch goes to `ST_STEP`.
- `ST_STEP`: shifts the mask and goes back to `ST_PICK`. When the mask shifts out it starts the second pass, or goes to `ST_DONE` after the second pass.
- `ST_DONE`: returns to `ST_IDLE` after one cycle.

Top module: `addr_alias_tester`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_en` are all 0.
- R2: The flip mask starts at the word size in bytes (DW/8) and moves left one bit per step. A pass ends when the mask shifts out of the AW-bit address. The reported `fail_mask` is the mask in use at the failing step.
- R3: A partner (test address XOR mask) below the base, or at or above base+size, causes no memory access.
- R4: For an in-range partner the memory sees three accesses in this order: a read of the partner, then a write to the test address of the bitwise complement of the data read, then a second read of the partner. Read data returns one cycle after the read.
- R5: A fault is flagged when the second partner read equals the complemented value written. The partner address is then reported on `fail_partner_addr`.
- R6: Pass one uses the base as the test address. Pass two uses base+size-DW/8. The failing test address is reported on `fail_test_addr`.
- R7: The run stops at the first fault. `done` is high for exactly one cycle at the end of the run. `fault` is 1 only if an aliasing pair was found.
- R8: `start` has no effect while `busy` is 1.
- R9: `fault` and the three report outputs hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| region_base | input | AW | Region base byte address, word aligned |
| region_size | input | AW+1 | Region size in bytes, a multiple of DW/8 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fault | output | 1 | An aliasing pair was found |
| fail_test_addr | output | AW | Test address of the failing pair |
| fail_partner_addr | output | AW | Partner address of the failing pair |
| fail_mask | output | AW | Flip mask of the failing pair |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |

## Verification
The compare at the highest mask bit of a pass falls in the same cycle as the decision to end that pass. A fault found there must win over the move to the next pass or the end of the run. The bench provokes this with a stuck-at fault on the top address bit over a full-size region. In that case only the last mask of pass one can reveal the alias. The check is that the reported mask is the top bit and that no second-pass access appears in the recorded memory traffic.

// File: rtl/aat_pkg.sv
package aat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_RD_A,
        ST_WR_T,
        ST_RD_B,
        ST_CMP,
        ST_STEP,
        ST_DONE
    } aat_state_e;

endpackage

// File: rtl/aat_partner.sv
module aat_partner #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] test_addr,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   limit,
    output logic [AW-1:0] partner,
    output logic          in_range
);

    always_comb begin
        partner  = test_addr ^ mask;
        in_range = ({1'b0, partner} >= {1'b0, base}) && ({1'b0, partner} < limit);
    end

endmodule

// File: rtl/aat_result.sv
module aat_result #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic [AW-1:0] test_addr,
    input  logic [AW-1:0] partner,
    input  logic [AW-1:0] mask,
    output logic          fault,
    output logic [AW-1:0] fail_test_addr,
    output logic [AW-1:0] fail_partner_addr,
    output logic [AW-1:0] fail_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault             <= 1'b0;
            fail_test_addr    <= '0;
            fail_partner_addr <= '0;
            fail_mask         <= '0;
        end else if (clear) begin
            fault             <= 1'b0;
            fail_test_addr    <= '0;
            fail_partner_addr <= '0;
            fail_mask         <= '0;
        end else if (capture) begin
            fault             <= 1'b1;
            fail_test_addr    <= test_addr;
            fail_partner_addr <= partner;
            fail_mask         <= mask;
        end
    end

    // R5: a fault is only ever recorded for a flip mask of one bit
    p_one_bit_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ($countones(test_addr ^ partner) == 1));

endmodule

// File: rtl/addr_alias_tester.sv
module addr_alias_tester
    import aat_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] region_base,
    input  logic [AW:0]   region_size,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] fail_test_addr,
    output logic [AW-1:0] fail_partner_addr,
    output logic [AW-1:0] fail_mask,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int            WB         = DW / 8;
    localparam logic [AW-1:0] FIRST_MASK = AW'(WB);
    localparam logic [AW:0]   WB_EXT     = (AW+1)'(WB);

    aat_state_e    state_q, state_d;
    logic [AW-1:0] base_q, test_q, last_q, mask_q;
    logic [AW:0]   limit_q;
    logic          pass_q;
    logic [DW-1:0] wr_q;
    logic [AW-1:0] partner;
    logic          in_range;
    logic          mask_out;
    logic          accept;
    logic          hit;

    aat_partner #(.AW(AW)) u_partner (
        .test_addr (test_q),
        .mask      (mask_q),
        .base      (base_q),
        .limit     (limit_q),
        .partner   (partner),
        .in_range  (in_range)
    );

    assign mask_out = ((mask_q << 1) == '0);
    assign accept   = (state_q == ST_IDLE) && start;
    assign hit      = (state_q == ST_CMP) && (mem_rdata == wr_q);

    aat_result #(.AW(AW)) u_result (
        .clk               (clk),
        .rst_n             (rst_n),
        .clear             (accept),
        .capture           (hit),
        .test_addr         (test_q),
        .partner           (partner),
        .mask              (mask_q),
        .fault             (fault),
        .fail_test_addr    (fail_test_addr),
        .fail_partner_addr (fail_partner_addr),
        .fail_mask         (fail_mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PICK;
            ST_PICK: state_d = in_range ? ST_RD_A : ST_STEP;
            ST_RD_A: state_d = ST_WR_T;
            ST_WR_T: state_d = ST_RD_B;
            ST_RD_B: state_d = ST_CMP;
            ST_CMP:  state_d = hit ? ST_DONE : ST_STEP;
            ST_STEP: state_d = (mask_out && pass_q) ? ST_DONE : ST_PICK;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            test_q  <= '0;
            last_q  <= '0;
            mask_q  <= '0;
            pass_q  <= 1'b0;
            wr_q    <= '0;
        end else begin
            if (accept) begin
                base_q  <= region_base;
                limit_q <= {1'b0, region_base} + region_size;
                test_q  <= region_base;
                last_q  <= AW'({1'b0, region_base} + region_size - WB_EXT);
                mask_q  <= FIRST_MASK;
                pass_q  <= 1'b0;
            end
            if (state_q == ST_WR_T) wr_q <= ~mem_rdata;
            if (state_q == ST_STEP) begin
                if (!mask_out) begin
                    mask_q <= mask_q << 1;
                end else if (!pass_q) begin
                    pass_q <= 1'b1;
                    test_q <= last_q;
                    mask_q <= FIRST_MASK;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = partner;
        mem_wdata = '0;
        unique case (state_q)
            ST_RD_A, ST_RD_B: mem_en = 1'b1;
            ST_WR_T: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = test_q;
                mem_wdata = ~mem_rdata;
            end
            default: ;
        endcase
    end

    // R1: no memory traffic while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R2: exactly one flip bit while running
    p_mask_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(mask_q) == 1));

    // R3: every read stays inside the captured region
    p_read_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (({1'b0, mem_addr} >= {1'b0, base_q}) && ({1'b0, mem_addr} < limit_q)));

    // R4: a write is always preceded by a read
    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $past(mem_en && !mem_we));

    // R4: the reread after a write targets the first read address
    p_reread_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (mem_en && !mem_we && mem_addr == $past(mem_addr, 2)));

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while busy leaves the region untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(base_q));

endmodule

// File: tb/addr_alias_tester_bench.sv
module addr_alias_tester_bench;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int WB = DW / 8;
    localparam int NW = (1 << AW) / WB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] region_base = '0;
    logic [AW:0]   region_size = '0;
    logic          busy, done, fault;
    logic [AW-1:0] fail_test_addr, fail_partner_addr, fail_mask;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    always #5 clk = ~clk;

    addr_alias_tester #(.AW(AW), .DW(DW)) u_addr_alias_tester (
        .clk(clk), .rst_n(rst_n), .start(start),
        .region_base(region_base), .region_size(region_size),
        .busy(busy), .done(done), .fault(fault),
        .fail_test_addr(fail_test_addr), .fail_partner_addr(fail_partner_addr),
        .fail_mask(fail_mask),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // faulty memory model: 0 none, 1 address bit stuck low, 2 stuck high
    int fmode = 0;
    int fbit  = 0;

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        logic [AW-1:0] b;
        b = AW'(1) << fbit;
        if (fmode == 1) return a & ~b;
        if (fmode == 2) return a | b;
        return a;
    endfunction

    logic [DW-1:0] mem [0:NW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= DW'(i) * 32'h9E3779B1 ^ 32'h3C5A0F00;
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) mem[phys(mem_addr) / WB] <= mem_wdata;
            else        mem_rdata <= mem[phys(mem_addr) / WB];
        end
    end

    // expected traffic
    logic [AW-1:0] exp_addr [0:63];
    logic          exp_we   [0:63];
    int            exp_n;
    logic          exp_fault;
    logic [AW-1:0] exp_t, exp_p, exp_m;

    int            acc_idx = 0;
    int            seq_bad = 0;
    logic [DW-1:0] last_rd = '0;

    always @(posedge clk) begin
        if (rst_n && mem_en) begin
            if (acc_idx >= exp_n || mem_addr != exp_addr[acc_idx] || mem_we != exp_we[acc_idx])
                seq_bad++;
            if (!mem_we) last_rd = mem[phys(mem_addr) / WB];
            else if (mem_wdata != ~last_rd) seq_bad++;
            acc_idx++;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic build_expected(input logic [AW-1:0] b, input logic [AW:0] s);
        logic [AW:0]   lim;
        logic [AW-1:0] t, p, m;
        exp_n = 0;
        exp_fault = 1'b0;
        exp_t = '0; exp_p = '0; exp_m = '0;
        lim = {1'b0, b} + s;
        for (int pass = 0; pass < 2 && !exp_fault; pass++) begin
            t = (pass == 0) ? b : AW'(lim - (AW+1)'(WB));
            m = AW'(WB);
            while (m != '0 && !exp_fault) begin
                p = t ^ m;
                if ({1'b0, p} >= {1'b0, b} && {1'b0, p} < lim) begin
                    exp_addr[exp_n] = p; exp_we[exp_n] = 1'b0; exp_n++;
                    exp_addr[exp_n] = t; exp_we[exp_n] = 1'b1; exp_n++;
                    exp_addr[exp_n] = p; exp_we[exp_n] = 1'b0; exp_n++;
                    if (phys(t) == phys(p)) begin
                        exp_fault = 1'b1; exp_t = t; exp_p = p; exp_m = m;
                    end
                end
                m = m << 1;
            end
        end
    endtask

    task automatic run_case(input logic [AW-1:0] b, input logic [AW:0] s,
                            input int fm, input int fb, input logic disturb);
        int cyc;
        logic [AW-1:0] hold_m;
        logic hold_f;
        fmode = fm;
        fbit  = fb;
        build_expected(b, s);
        acc_idx = 0;
        seq_bad = 0;
        @(negedge clk);
        region_base = b;
        region_size = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            region_base = b ^ AW'(WB * 2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(done, disturb ? "R8 run completes" : "R7 done seen", 32'(done), 32'd1);
        check(fault == exp_fault, "R5 R7 fault verdict", 32'(fault), 32'(exp_fault));
        if (exp_fault) begin
            check(fail_test_addr == exp_t, "R6 test address", 32'(fail_test_addr), 32'(exp_t));
            check(fail_partner_addr == exp_p, "R5 partner address", 32'(fail_partner_addr), 32'(exp_p));
            check(fail_mask == exp_m, "R2 flip mask", 32'(fail_mask), 32'(exp_m));
        end
        check(acc_idx == exp_n, "R3 access count", 32'(acc_idx), 32'(exp_n));
        check(seq_bad == 0, disturb ? "R8 traffic unchanged" : "R4 access order and data",
              32'(seq_bad), 32'd0);
        hold_m = fail_mask;
        hold_f = fault;
        @(negedge clk);
        check(!done && !busy, "R7 single done pulse", 32'({done, busy}), 32'd0);
        repeat (2) @(negedge clk);
        check(fault == hold_f && fail_mask == hold_m, "R9 results held",
              32'({fault, fail_mask}), 32'({hold_f, hold_m}));
    endtask

    initial begin
        logic [AW-1:0] bases [0:4];
        logic [AW:0]   sizes [0:4];
        bases[0] = 10'h000; sizes[0] = 11'h400;
        bases[1] = 10'h100; sizes[1] = 11'h100;
        bases[2] = 10'h200; sizes[2] = 11'h080;
        bases[3] = 10'h030; sizes[3] = 11'h1C8;
        bases[4] = 10'h3FC; sizes[4] = 11'h004;
        exp_n = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault && !mem_en, "R1 reset state",
              32'({busy, done, fault, mem_en}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_en, "R1 idle after reset", 32'({busy, mem_en}), 32'd0);

        for (int r = 0; r < 5; r++) begin
            run_case(bases[r], sizes[r], 0, 0, 1'b0);
            for (int k = 2; k < AW; k++) begin
                run_case(bases[r], sizes[r], 1, k, 1'b0);
                run_case(bases[r], sizes[r], 2, k, 1'b0);
            end
        end
        // top mask bit is the only one that reveals the alias
        run_case(10'h000, 11'h400, 1, AW - 1, 1'b0);
        // start pulses during a run are ignored
        run_case(10'h100, 11'h200, 0, 0, 1'b1);
        run_case(10'h000, 11'h400, 2, 5, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int wd;
        wd = 0;
        while (wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", wd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule